// File: doc/BRIEF.md
# Instruction Sampling Profile Unit

This unit sits beside a pipeline and picks single fetched instructions to follow through to completion. A down-counter is decremented by every fetched instruction. When a fetch finds the counter at zero, that instruction is the one sampled, and the unit raises a tag for it in the same cycle. The pipeline carries the tag with the instruction. While the tagged instruction moves through its stages, the pipeline reports to the unit which stage currently holds it, and reports that instruction's execute-stage results. Each reload of the counter subtracts a pseudo-random offset of 0 to 15 from the programmed period, so samples do not lock onto loop periodicity.

The unit records the following per sample:
- the fetch PC, the instruction-cache miss flag and the branch history at fetch;
- the data address, the data-cache miss flag, the mispredict flag and the branch direction;
- a saturating residency count for each of the map, issue, execute and retire stages.

When the tagged instruction finishes, either retired or squashed, these values are frozen into capture outputs and an interrupt is raised. The interrupt holds until software acknowledges it. Until that acknowledge, no new tag is issued, and counter overflows in that period are counted as dropped samples.

Top module: `isamp_unit`

## Requirements
- R1: The counter is decremented only by cycles with `fetch_valid_i` high. A fetch that finds it at zero is an overflow, and the counter then reloads with the period minus the low 4 bits of a 16-bit LFSR (floored at 0). The first reload happens in the first cycle after reset. With period P ≥ 15, the first tag after reset therefore falls on fetch number P-14 to P+1.
- R2: `tag_o` is high for exactly the one fetch that is sampled. It stays low for every fetch from then until the capture is acknowledged.
- R3: The capture holds the tagged instruction's fetch PC, its instruction-miss flag and its branch history at fetch.
- R4: The capture holds the data address, the data-miss flag and the mispredict flag reported with `exec_rpt_i` for the tagged instruction.
- R5: `cap_dir_o` equals the reported taken bit when the tagged instruction was flagged as a conditional branch at fetch, and is 0 otherwise.
- R6: `cap_lat_o` holds four 8-bit counts: map in bits [7:0], issue in [15:8], execute in [23:16], retire in [31:24]. Each count is the number of cycles the matching `stage_i` bit (bit 0 = map … bit 3 = retire) was high while tracking, including the cycle with `done_i`. Each count saturates at 255.
- R7: `done_i` makes `irq_o` rise at the next clock edge, with all capture outputs valid. The interrupt rises exactly once per completed sample, and the captures stay stable while it is high.
- R8: A completion with `done_retired_i` low gives `cap_retired_o` = 0 and `cap_lat_ok_o` = 0. A retired completion gives 1 for both.
- R9: `irq_o` stays high until `ack_i`, and is low one cycle after the acknowledge. An acknowledge while `irq_o` is low has no effect.
- R10: An overflow while a sample is in flight or awaiting acknowledge increments `drop_cnt_o`, which saturates at 255 and is cleared only by reset. Overflows while idle do not change it.
- R11: After reset, `irq_o`, `tag_o` and `drop_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 16 | Sampling period in fetched instructions |
| ack_i | input | 1 | Software acknowledge of the capture |
| fetch_valid_i | input | 1 | An instruction is fetched this cycle |
| fetch_pc_i | input | 32 | PC of the fetched instruction |
| fetch_imiss_i | input | 1 | Fetch missed the instruction cache |
| fetch_cbr_i | input | 1 | Fetched instruction is a conditional branch |
| fetch_hist_i | input | 8 | Global branch history at fetch |
| tag_o | output | 1 | Mark this fetched instruction as the sample |
| stage_i | input | 4 | Stage holding the tagged instruction (map, issue, execute, retire) |
| exec_rpt_i | input | 1 | Execute results of the tagged instruction are valid |
| exec_ea_i | input | 32 | Effective data address |
| exec_dmiss_i | input | 1 | Data-cache miss |
| exec_mispred_i | input | 1 | Branch mispredicted |
| exec_taken_i | input | 1 | Branch taken |
| done_i | input | 1 | Tagged instruction completed |
| done_retired_i | input | 1 | Completion was a retire, not a squash |
| irq_o | output | 1 | Capture ready interrupt |
| cap_pc_o | output | 32 | Captured PC |
| cap_ea_o | output | 32 | Captured data address |
| cap_imiss_o | output | 1 | Captured instruction-miss flag |
| cap_dmiss_o | output | 1 | Captured data-miss flag |
| cap_mispred_o | output | 1 | Captured mispredict flag |
| cap_dir_o | output | 1 | Captured branch direction |
| cap_hist_o | output | 8 | Captured branch history |
| cap_retired_o | output | 1 | Sample retired |
| cap_lat_o | output | 32 | Per-stage residency counts |
| cap_lat_ok_o | output | 1 | Retire-dependent counts are valid |
| drop_cnt_o | output | 8 | Dropped-sample count |

## Verification
The bench gives each fetched PC its own miss, branch-kind and history pattern. A unit that latched the wrong fetch would therefore report a mismatched history or flags, not just a wrong PC. A non-branch is sampled with taken driven high, which catches a direction bit that ignores the branch-kind flag. A squash in the execute stage checks that the retired and valid flags drop while the earlier counts remain. A 260-cycle execute stall shows whether a residency count wraps instead of saturating. With the period at zero, fetches during tracking must give an exact drop count, and 300 more fetches while the interrupt is held must pin it at 255 with no second tag or interrupt. A stray acknowledge with no capture pending must leave the interrupt and drop count unchanged.

// File: rtl/isamp_pkg.sv
package isamp_pkg;
  typedef enum logic [1:0] {
    SMP_ARM   = 2'd0,
    SMP_COUNT = 2'd1,
    SMP_TRACK = 2'd2,
    SMP_HOLD  = 2'd3
  } smp_state_e;
endpackage

// File: rtl/isamp_lfsr.sv
module isamp_lfsr #(
  parameter int RW   = 16,
  parameter int OUTW = 4,
  parameter logic [RW-1:0] SEED = 16'hACE1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [OUTW-1:0] rnd_o
);
  logic [RW-1:0] st;
  logic          fb;

  // x^16 + x^14 + x^13 + x^11 + 1
  assign fb    = st[RW-1] ^ st[RW-3] ^ st[RW-4] ^ st[RW-6];
  assign rnd_o = st[OUTW-1:0];

  always_ff @(posedge clk) begin
    if (rst) st <= SEED;
    else     st <= {st[RW-2:0], fb};
  end
endmodule

// File: rtl/isamp_fetch_ctr.sv
module isamp_fetch_ctr #(
  parameter int CW   = 16,
  parameter int OFFW = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            fetch_i,
  input  logic            busy_i,
  input  logic [CW-1:0]   period_i,
  input  logic [OFFW-1:0] off_i,
  output logic            ovf_o,
  output logic [DW-1:0]   drop_o
);
  localparam logic [DW-1:0] DROP_MAX = {DW{1'b1}};

  logic [CW-1:0] cnt;
  logic [CW-1:0] off_ext;
  logic [CW-1:0] reload;

  assign off_ext = {{(CW-OFFW){1'b0}}, off_i};
  assign reload  = (period_i > off_ext) ? (period_i - off_ext) : '0;
  assign ovf_o   = fetch_i && !load_i && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      drop_o <= '0;
    end else if (load_i) begin
      cnt <= reload;
    end else if (fetch_i) begin
      if (cnt == '0) begin
        cnt <= reload;
        if (busy_i && drop_o != DROP_MAX) drop_o <= drop_o + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_DROP_SAT: assert property (@(posedge clk) disable iff (rst)
    (drop_o == DROP_MAX) |=> (drop_o == DROP_MAX)); // R10
  AST_DROP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_i && !load_i) |=> $stable(drop_o)); // R10
endmodule

// File: rtl/isamp_stage_lat.sv
module isamp_stage_lat #(
  parameter int NSTG = 4,
  parameter int LW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [NSTG-1:0]    stage_i,
  output logic [NSTG*LW-1:0] nxt_o
);
  localparam logic [LW-1:0] LAT_MAX = {LW{1'b1}};

  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    logic [LW-1:0] cur;
    logic [LW-1:0] nxt;

    assign nxt = (en_i && stage_i[k] && cur != LAT_MAX) ? cur + 1'b1 : cur;
    assign nxt_o[k*LW +: LW] = nxt;

    always_ff @(posedge clk) begin
      if (rst || clr_i) cur <= '0;
      else              cur <= nxt;
    end

    AST_LAT_SAT: assert property (@(posedge clk) disable iff (rst)
      (!clr_i && cur == LAT_MAX) |=> (cur == LAT_MAX)); // R6
  end
endmodule

// File: rtl/isamp_unit.sv
module isamp_unit
  import isamp_pkg::*;
#(
  parameter int PCW  = 32,
  parameter int AW   = 32,
  parameter int HW   = 8,
  parameter int CW   = 16,
  parameter int OFFW = 4,
  parameter int NSTG = 4,
  parameter int LW   = 8,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CW-1:0]      period_i,
  input  logic               ack_i,
  input  logic               fetch_valid_i,
  input  logic [PCW-1:0]     fetch_pc_i,
  input  logic               fetch_imiss_i,
  input  logic               fetch_cbr_i,
  input  logic [HW-1:0]      fetch_hist_i,
  output logic               tag_o,
  input  logic [NSTG-1:0]    stage_i,
  input  logic               exec_rpt_i,
  input  logic [AW-1:0]      exec_ea_i,
  input  logic               exec_dmiss_i,
  input  logic               exec_mispred_i,
  input  logic               exec_taken_i,
  input  logic               done_i,
  input  logic               done_retired_i,
  output logic               irq_o,
  output logic [PCW-1:0]     cap_pc_o,
  output logic [AW-1:0]      cap_ea_o,
  output logic               cap_imiss_o,
  output logic               cap_dmiss_o,
  output logic               cap_mispred_o,
  output logic               cap_dir_o,
  output logic [HW-1:0]      cap_hist_o,
  output logic               cap_retired_o,
  output logic [NSTG*LW-1:0] cap_lat_o,
  output logic               cap_lat_ok_o,
  output logic [DW-1:0]      drop_cnt_o
);
  smp_state_e         state;
  logic [OFFW-1:0]    rnd;
  logic               ovf;
  logic               busy;
  logic               tracking;
  logic [NSTG*LW-1:0] lat_nxt;

  logic [PCW-1:0] w_pc;
  logic [AW-1:0]  w_ea;
  logic [HW-1:0]  w_hist;
  logic           w_imiss, w_cbr, w_dmiss, w_mis, w_taken;

  assign busy     = (state == SMP_TRACK) || (state == SMP_HOLD);
  assign tracking = (state == SMP_TRACK);
  assign tag_o    = (state == SMP_COUNT) && ovf;

  isamp_lfsr #(.RW(16), .OUTW(OFFW)) u_lfsr (
    .clk(clk), .rst(rst), .rnd_o(rnd)
  );

  isamp_fetch_ctr #(.CW(CW), .OFFW(OFFW), .DW(DW)) u_ctr (
    .clk(clk), .rst(rst), .load_i(state == SMP_ARM), .fetch_i(fetch_valid_i),
    .busy_i(busy), .period_i(period_i), .off_i(rnd), .ovf_o(ovf),
    .drop_o(drop_cnt_o)
  );

  isamp_stage_lat #(.NSTG(NSTG), .LW(LW)) u_lat (
    .clk(clk), .rst(rst), .clr_i(tag_o), .en_i(tracking),
    .stage_i(stage_i), .nxt_o(lat_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SMP_ARM;
      irq_o <= 1'b0;
    end else begin
      case (state)
        SMP_ARM:   state <= SMP_COUNT;
        SMP_COUNT: if (tag_o) state <= SMP_TRACK;
        SMP_TRACK: if (done_i) begin
          state <= SMP_HOLD;
          irq_o <= 1'b1;
        end
        SMP_HOLD:  if (ack_i) begin
          state <= SMP_COUNT;
          irq_o <= 1'b0;
        end
        default:   state <= SMP_ARM;
      endcase
    end
  end

  // working record of the tagged instruction
  always_ff @(posedge clk) begin
    if (rst) begin
      w_pc <= '0; w_hist <= '0; w_imiss <= 1'b0; w_cbr <= 1'b0;
      w_ea <= '0; w_dmiss <= 1'b0; w_mis <= 1'b0; w_taken <= 1'b0;
    end else if (tag_o) begin
      w_pc <= fetch_pc_i; w_hist <= fetch_hist_i;
      w_imiss <= fetch_imiss_i; w_cbr <= fetch_cbr_i;
      w_ea <= '0; w_dmiss <= 1'b0; w_mis <= 1'b0; w_taken <= 1'b0;
    end else if (tracking && exec_rpt_i) begin
      w_ea <= exec_ea_i; w_dmiss <= exec_dmiss_i;
      w_mis <= exec_mispred_i; w_taken <= exec_taken_i;
    end
  end

  // frozen capture registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_pc_o <= '0; cap_ea_o <= '0; cap_imiss_o <= 1'b0; cap_dmiss_o <= 1'b0;
      cap_mispred_o <= 1'b0; cap_dir_o <= 1'b0; cap_hist_o <= '0;
      cap_retired_o <= 1'b0; cap_lat_o <= '0; cap_lat_ok_o <= 1'b0;
    end else if (tracking && done_i) begin
      cap_pc_o      <= w_pc;
      cap_ea_o      <= w_ea;
      cap_imiss_o   <= w_imiss;
      cap_dmiss_o   <= w_dmiss;
      cap_mispred_o <= w_mis;
      cap_dir_o     <= w_cbr & w_taken;
      cap_hist_o    <= w_hist;
      cap_retired_o <= done_retired_i;
      cap_lat_o     <= lat_nxt;
      cap_lat_ok_o  <= done_retired_i;
    end
  end

  AST_ONE_TAG: assert property (@(posedge clk) disable iff (rst)
    tag_o |=> !tag_o); // R2
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> irq_o); // R9
  AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> ($stable(cap_pc_o) && $stable(cap_lat_o) && $stable(cap_retired_o))); // R7
  AST_NO_TAG_IRQ: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !tag_o); // R2
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i) |=> !irq_o); // R9
endmodule

// File: tb/isamp_unit_test.sv
module isamp_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] period_i = 16'd40;
  logic        ack_i = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        fetch_imiss_i = 1'b0;
  logic        fetch_cbr_i = 1'b0;
  logic [7:0]  fetch_hist_i = '0;
  logic        tag_o;
  logic [3:0]  stage_i = '0;
  logic        exec_rpt_i = 1'b0;
  logic [31:0] exec_ea_i = '0;
  logic        exec_dmiss_i = 1'b0;
  logic        exec_mispred_i = 1'b0;
  logic        exec_taken_i = 1'b0;
  logic        done_i = 1'b0;
  logic        done_retired_i = 1'b0;
  logic        irq_o;
  logic [31:0] cap_pc_o, cap_ea_o;
  logic        cap_imiss_o, cap_dmiss_o, cap_mispred_o, cap_dir_o;
  logic [7:0]  cap_hist_o;
  logic        cap_retired_o;
  logic [31:0] cap_lat_o;
  logic        cap_lat_ok_o;
  logic [7:0]  drop_cnt_o;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] ea;
    logic        imiss, dmiss, mis, dir;
    logic [7:0]  hist;
    logic        ret, latok;
    logic [31:0] lat;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  int   rises = 0;
  int   samples = 0;
  int   cyc = 0;
  bit   finished = 1'b0;
  logic irq_prev = 1'b0;

  always #5 clk = ~clk;

  isamp_unit uut (
    .clk(clk), .rst(rst), .period_i(period_i), .ack_i(ack_i),
    .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
    .fetch_imiss_i(fetch_imiss_i), .fetch_cbr_i(fetch_cbr_i),
    .fetch_hist_i(fetch_hist_i), .tag_o(tag_o), .stage_i(stage_i),
    .exec_rpt_i(exec_rpt_i), .exec_ea_i(exec_ea_i), .exec_dmiss_i(exec_dmiss_i),
    .exec_mispred_i(exec_mispred_i), .exec_taken_i(exec_taken_i),
    .done_i(done_i), .done_retired_i(done_retired_i), .irq_o(irq_o),
    .cap_pc_o(cap_pc_o), .cap_ea_o(cap_ea_o), .cap_imiss_o(cap_imiss_o),
    .cap_dmiss_o(cap_dmiss_o), .cap_mispred_o(cap_mispred_o),
    .cap_dir_o(cap_dir_o), .cap_hist_o(cap_hist_o),
    .cap_retired_o(cap_retired_o), .cap_lat_o(cap_lat_o),
    .cap_lat_ok_o(cap_lat_ok_o), .drop_cnt_o(drop_cnt_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sat8(input int n);
    return (n > 255) ? 8'd255 : n[7:0];
  endfunction

  // per-PC stimulus attributes
  function automatic logic [7:0] hist_of(input logic [31:0] pc);
    return pc[9:2] ^ 8'h5A;
  endfunction

  task automatic fetch_one(input logic [31:0] pc, output logic tg);
    fetch_valid_i = 1'b1;
    fetch_pc_i    = pc;
    fetch_imiss_i = pc[3];
    fetch_cbr_i   = pc[4];
    fetch_hist_i  = hist_of(pc);
    #1 tg = tag_o;
    @(negedge clk);
    fetch_valid_i = 1'b0;
  endtask

  // driver: find the tagged fetch, walk it through the stages, push expectation
  task automatic do_sample(input logic [31:0] base, input logic [31:0] ea,
                           input logic taken, input logic dmiss, input logic mis,
                           input int nm, input int ni, input int ne, input int nr,
                           input logic ret, input int nx,
                           input int win_lo, input int win_hi);
    int          k = 0;
    logic        tg = 1'b0;
    logic [31:0] pc = '0;
    exp_t        e;
    while (!tg && k < 200) begin
      pc = base + 32'(4 * k);
      k++;
      fetch_one(pc, tg);
    end
    check(tg, "R1", "tag seen", {31'd0, tg}, 32'd1);
    if (win_lo >= 0)
      check(k >= win_lo && k <= win_hi, "R1", "first tag fetch index", k, win_lo);
    for (int i = 0; i < nm; i++) begin
      stage_i = 4'b0001;
      if (i < nx) begin
        fetch_valid_i = 1'b1;
        fetch_pc_i    = 32'h9000 + 32'(4 * i);
        #1 check(tag_o == 1'b0, "R2", "no tag while tracking", {31'd0, tag_o}, 32'd0);
      end
      @(negedge clk);
      fetch_valid_i = 1'b0;
    end
    for (int i = 0; i < ni; i++) begin
      stage_i = 4'b0010;
      @(negedge clk);
    end
    for (int i = 0; i < ne; i++) begin
      stage_i        = 4'b0100;
      exec_rpt_i     = (i == 0);
      exec_ea_i      = ea;
      exec_dmiss_i   = dmiss;
      exec_mispred_i = mis;
      exec_taken_i   = taken;
      done_i         = !ret && (i == ne - 1);
      done_retired_i = 1'b0;
      @(negedge clk);
      exec_rpt_i = 1'b0;
    end
    for (int i = 0; i < nr; i++) begin
      stage_i        = 4'b1000;
      done_i         = (i == nr - 1);
      done_retired_i = 1'b1;
      @(negedge clk);
    end
    stage_i = '0; done_i = 1'b0; done_retired_i = 1'b0;
    e.pc = pc; e.ea = ea; e.imiss = pc[3]; e.dmiss = dmiss; e.mis = mis;
    e.dir = pc[4] & taken; e.hist = hist_of(pc); e.ret = ret; e.latok = ret;
    e.lat = {ret ? sat8(nr) : 8'd0, sat8(ne), sat8(ni), sat8(nm)};
    q.push_back(e);
    samples++;
  endtask

  task automatic ack_irq();
    @(negedge clk);
    check(irq_o == 1'b1, "R9", "irq held before ack", {31'd0, irq_o}, 32'd1);
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    check(irq_o == 1'b0, "R9", "irq cleared after ack", {31'd0, irq_o}, 32'd0);
  endtask

  // monitor: scoreboard comparison on each interrupt rise
  always @(negedge clk) begin
    if (irq_o && !irq_prev) begin
      rises++;
      if (q.size() == 0) begin
        check(1'b0, "R7", "irq without completed sample", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cap_pc_o == e.pc, "R3", "pc", cap_pc_o, e.pc);
        check(cap_imiss_o == e.imiss, "R3", "imiss", {31'd0, cap_imiss_o}, {31'd0, e.imiss});
        check(cap_hist_o == e.hist, "R3", "history", {24'd0, cap_hist_o}, {24'd0, e.hist});
        check(cap_ea_o == e.ea, "R4", "ea", cap_ea_o, e.ea);
        check(cap_dmiss_o == e.dmiss, "R4", "dmiss", {31'd0, cap_dmiss_o}, {31'd0, e.dmiss});
        check(cap_mispred_o == e.mis, "R4", "mispredict", {31'd0, cap_mispred_o}, {31'd0, e.mis});
        check(cap_dir_o == e.dir, "R5", "direction", {31'd0, cap_dir_o}, {31'd0, e.dir});
        check(cap_lat_o == e.lat, "R6", "latencies", cap_lat_o, e.lat);
        check(cap_retired_o == e.ret, "R8", "retired", {31'd0, cap_retired_o}, {31'd0, e.ret});
        check(cap_lat_ok_o == e.latok, "R8", "latency valid", {31'd0, cap_lat_ok_o}, {31'd0, e.latok});
      end
    end
    irq_prev = irq_o;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(1'b0, "WDOG", "watchdog expired", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(irq_o == 1'b0, "R11", "irq after reset", {31'd0, irq_o}, 32'd0);
    check(drop_cnt_o == 8'd0, "R11", "drop after reset", {24'd0, drop_cnt_o}, 32'd0);
    check(tag_o == 1'b0, "R11", "tag after reset", {31'd0, tag_o}, 32'd0);
    @(negedge clk);
    @(negedge clk);

    // A: retired conditional branch, taken; period 40 window
    do_sample(32'h1000, 32'hDEAD0040, 1'b1, 1'b0, 1'b0, 2, 1, 3, 2, 1'b1, 0, 26, 41);
    ack_irq();

    // B: data miss + mispredict, taken driven high (dir depends on branch kind)
    do_sample(32'h2004, 32'h0BAD0F00, 1'b1, 1'b1, 1'b1, 1, 4, 2, 1, 1'b1, 0, -1, -1);
    ack_irq();

    // C: squash in execute, R8
    do_sample(32'h3010, 32'h00001234, 1'b0, 1'b1, 1'b0, 3, 2, 2, 0, 1'b0, 0, -1, -1);
    ack_irq();

    // D: long execute stall, saturation R6
    do_sample(32'h4000, 32'h55550000, 1'b1, 1'b0, 1'b1, 1, 1, 260, 1, 1'b1, 0, -1, -1);
    ack_irq();

    // stray ack with nothing pending, R9 / R10
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    @(negedge clk);
    check(irq_o == 1'b0, "R9", "stray ack leaves irq low", {31'd0, irq_o}, 32'd0);
    check(drop_cnt_o == 8'd0, "R10", "no drops while idle", {24'd0, drop_cnt_o}, 32'd0);
    check(rises == 4, "R7", "one irq per sample", rises, 4);

    // E: period 0, fetches while busy become drops
    period_i = 16'd0;
    do_sample(32'h5000, 32'h77770000, 1'b0, 1'b0, 1'b0, 6, 1, 1, 1, 1'b1, 5, -1, -1);
    @(negedge clk);
    check(drop_cnt_o == 8'd5, "R10", "drops during tracking", {24'd0, drop_cnt_o}, 32'd5);
    for (int i = 0; i < 300; i++) begin
      fetch_valid_i = 1'b1;
      fetch_pc_i    = 32'hA000 + 32'(4 * i);
      #1 if (tag_o) check(1'b0, "R2", "tag while capture pending", 32'd1, 32'd0);
      @(negedge clk);
    end
    fetch_valid_i = 1'b0;
    check(drop_cnt_o == 8'd255, "R10", "drop saturates", {24'd0, drop_cnt_o}, 32'd255);
    check(irq_o == 1'b1, "R9", "irq held through drops", {31'd0, irq_o}, 32'd1);
    ack_irq();
    check(drop_cnt_o == 8'd255, "R10", "drop kept after ack", {24'd0, drop_cnt_o}, 32'd255);
    check(rises == samples, "R7", "irq rises equal samples", rises, samples);
    check(q.size() == 0, "R7", "scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule